// File: doc/BRIEF.md
# Harmonic Proportion Scaling Mixer

This block builds one composite waveform sample out of a fundamental sine sample and three odd-harmonic samples (third, fifth and seventh). Each harmonic is weighted by a programmable whole-number percentage. The fundamental passes through at full scale. A harmonic is weighted by multiplying its signed sample by its proportion word. The signed product is then divided by the constant 100, and only the integer quotient is kept. The three quotients are added to the fundamental.

The four sample streams arrive in parallel, qualified by one valid strobe. A sample set is taken in only while the active-low enable is held low. Each accepted set produces one result after a fixed pipeline delay. The result is widened so that no combination of samples and legal weights can overflow it. The upstream sine generators and any later conversion to analog are not part of this block.

Top module: `harm_mixer`

## Requirements
- R1: For every accepted set, outSum equals fundIn + q(harm3In,prop3) + q(harm5In,prop5) + q(harm7In,prop7), where q(h,p) is the signed product h*p divided by 100 with the remainder discarded.
- R2: The divide by 100 truncates toward zero, so a negative product never rounds down. For example, h = -1 with p = 50 gives 0, and h = -128 with p = 50 gives -64.
- R3: A proportion word above 50 (any value from 51 to 127 of the 7-bit field) acts exactly as 50.
- R4: With all three proportion words at 0, outSum equals the fundamental sample, sign-extended.
- R5: outValid is high exactly 3 clock cycles after the rising edge that accepted an input set.
- R6: An input valid presented while enN is high is ignored: no result is produced for it.
- R7: While rst is high, and on the first cycle after it, outValid is low and outSum is 0.
- R8: outSum holds its value in every cycle in which outValid is low.
- R9: Sets accepted on consecutive cycles give results on consecutive cycles, one per clock, in the order they were accepted.
- R10: outSum is SAMPLE_W+2 bits wide. It holds the exact sum for the extreme samples (-128 and 127 at the default width) with all weights at their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enN | input | 1 | Active-low enable; input sets are accepted only while low |
| inValid | input | 1 | Marks the four sample inputs as a new set |
| fundIn | input | SAMPLE_W | Signed fundamental sample |
| harm3In | input | SAMPLE_W | Signed third-harmonic sample |
| harm5In | input | SAMPLE_W | Signed fifth-harmonic sample |
| harm7In | input | SAMPLE_W | Signed seventh-harmonic sample |
| prop3 | input | PROP_W | Third-harmonic percentage, 0 to 50 |
| prop5 | input | PROP_W | Fifth-harmonic percentage, 0 to 50 |
| prop7 | input | PROP_W | Seventh-harmonic percentage, 0 to 50 |
| outValid | output | 1 | Marks outSum as a new result |
| outSum | output | SAMPLE_W+2 | Signed composite sample |

## Verification
Two events can land in the same cycle: a new set being accepted at the input, and the result of an earlier set leaving the output. Long back-to-back streams with enN held low keep both happening together in every cycle. Random streams with enN toggling mix accepted sets with refused ones. A scoreboard tags each expected result with its acceptance cycle and judges both the value and the exact arrival cycle. Any output strobe that has no queued expectation is reported as a refused input that leaked through.

// File: rtl/harm_mixer_pkg.sv
package harm_mixer_pkg;
  localparam int HARM_N = 3;

  typedef struct packed {
    logic capture;
    logic mult;
    logic sum;
  } mixStrobe_t;
endpackage

// File: rtl/harm_mixer_ctrl.sv
module harm_mixer_ctrl
  import harm_mixer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enN,
  input  logic       inValid,
  output mixStrobe_t strobe,
  output logic       outValid
);
  logic [2:0] stageVld;
  logic accept;

  assign accept = inValid & ~enN;

  always_ff @(posedge clk) begin
    if (rst) stageVld <= '0;
    else     stageVld <= {stageVld[1:0], accept};
  end

  assign strobe.capture = accept;
  assign strobe.mult    = stageVld[0];
  assign strobe.sum     = stageVld[1];
  assign outValid       = stageVld[2];
endmodule

// File: rtl/harm_mixer_dp.sv
module harm_mixer_dp
  import harm_mixer_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int PROP_W   = 7,
  parameter int MAX_PCT  = 50,
  parameter int DIVISOR  = 100
)(
  input  logic                           clk,
  input  logic                           rst,
  input  mixStrobe_t                     strobe,
  input  logic signed [SAMPLE_W-1:0]     fundIn,
  input  logic [HARM_N*SAMPLE_W-1:0]     harmBus,
  input  logic [HARM_N*PROP_W-1:0]       propBus,
  output logic signed [SAMPLE_W+1:0]     outSum
);
  localparam int OUT_W  = SAMPLE_W + 2;
  localparam int PROD_W = SAMPLE_W + PROP_W + 1;
  localparam logic signed [PROD_W-1:0] DIV_S = PROD_W'(DIVISOR);
  localparam logic [PROP_W-1:0] MAX_P = PROP_W'(MAX_PCT);

  logic signed [SAMPLE_W-1:0] fundQ1, fundQ2;
  logic signed [PROD_W-1:0]   quot [HARM_N];
  logic signed [OUT_W-1:0]    sumNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      fundQ1 <= '0;
      fundQ2 <= '0;
    end else begin
      if (strobe.capture) fundQ1 <= fundIn;
      if (strobe.mult)    fundQ2 <= fundQ1;
    end
  end

  for (genvar i = 0; i < HARM_N; i++) begin : g_harm
    logic signed [SAMPLE_W-1:0] harmQ;
    logic [PROP_W-1:0]          propQ;
    logic signed [PROD_W-1:0]   prodQ;
    logic [PROP_W-1:0]          propRaw;

    assign propRaw = propBus[i*PROP_W +: PROP_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        harmQ <= '0;
        propQ <= '0;
        prodQ <= '0;
      end else begin
        if (strobe.capture) begin
          harmQ <= $signed(harmBus[i*SAMPLE_W +: SAMPLE_W]);
          propQ <= (propRaw > MAX_P) ? MAX_P : propRaw;
        end
        if (strobe.mult)
          prodQ <= PROD_W'(harmQ) * $signed({{(PROD_W-PROP_W){1'b0}}, propQ});
      end
    end

    assign quot[i] = prodQ / DIV_S;
  end

  always_comb begin
    sumNext = OUT_W'(fundQ2);
    for (int i = 0; i < HARM_N; i++)
      sumNext = sumNext + $signed(quot[i][OUT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)             outSum <= '0;
    else if (strobe.sum) outSum <= sumNext;
  end
endmodule

// File: rtl/harm_mixer.sv
module harm_mixer
  import harm_mixer_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int PROP_W   = 7,
  parameter int MAX_PCT  = 50,
  parameter int DIVISOR  = 100
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] fundIn,
  input  logic signed [SAMPLE_W-1:0] harm3In,
  input  logic signed [SAMPLE_W-1:0] harm5In,
  input  logic signed [SAMPLE_W-1:0] harm7In,
  input  logic [PROP_W-1:0]          prop3,
  input  logic [PROP_W-1:0]          prop5,
  input  logic [PROP_W-1:0]          prop7,
  output logic                       outValid,
  output logic signed [SAMPLE_W+1:0] outSum
);
  mixStrobe_t strobe;

  harm_mixer_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enN      (enN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  harm_mixer_dp #(
    .SAMPLE_W (SAMPLE_W),
    .PROP_W   (PROP_W),
    .MAX_PCT  (MAX_PCT),
    .DIVISOR  (DIVISOR)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .fundIn  (fundIn),
    .harmBus ({harm7In, harm5In, harm3In}),
    .propBus ({prop7, prop5, prop3}),
    .outSum  (outSum)
  );
endmodule

// File: rtl/harm_mixer_chk.sv
module harm_mixer_chk #(
  parameter int SAMPLE_W = 8,
  parameter int MAX_PCT  = 50,
  parameter int DIVISOR  = 100
)(
  input logic                       clk,
  input logic                       rst,
  input logic                       enN,
  input logic                       inValid,
  input logic                       outValid,
  input logic signed [SAMPLE_W+1:0] outSum
);
  localparam int HI = (1 << (SAMPLE_W-1)) - 1;
  localparam int LO = -(1 << (SAMPLE_W-1));
  localparam int MAX_V = HI + 3 * ((HI * MAX_PCT) / DIVISOR);
  localparam int MIN_V = LO - 3 * ((-LO * MAX_PCT) / DIVISOR);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !enN) |-> ##3 outValid);

  // R6
  refused_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && enN) |-> ##3 !outValid);

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outSum == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outSum));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outSum) <= MAX_V && int'(outSum) >= MIN_V));
endmodule

bind harm_mixer harm_mixer_chk #(
  .SAMPLE_W (SAMPLE_W),
  .MAX_PCT  (MAX_PCT),
  .DIVISOR  (DIVISOR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enN      (enN),
  .inValid  (inValid),
  .outValid (outValid),
  .outSum   (outSum)
);

// File: tb/harm_mixer_bench.sv
module harm_mixer_bench;
  localparam int SW = 8;
  localparam int PW = 7;

  logic clk = 0;
  logic rst = 1;
  logic enN = 1;
  logic inValid = 0;
  logic signed [SW-1:0] fundIn = 0, harm3In = 0, harm5In = 0, harm7In = 0;
  logic [PW-1:0] prop3 = 0, prop5 = 0, prop7 = 0;
  logic outValid;
  logic signed [SW+1:0] outSum;

  int checks = 0, failures = 0, cycCnt = 0;
  int expQ[$];
  int cycQ[$];
  string tagQ[$];
  int lastSum = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  harm_mixer u_harm_mixer (
    .clk(clk), .rst(rst), .enN(enN), .inValid(inValid),
    .fundIn(fundIn), .harm3In(harm3In), .harm5In(harm5In), .harm7In(harm7In),
    .prop3(prop3), .prop5(prop5), .prop7(prop7),
    .outValid(outValid), .outSum(outSum)
  );

  function automatic int scaled(int h, int p);
    int pp, prod, mag;
    pp = (p > 50) ? 50 : p;
    prod = h * pp;
    mag = ((prod < 0) ? -prod : prod) / 100;
    return (prod < 0) ? -mag : mag;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int f, int h3, int h5, int h7, int p3, int p5, int p7,
                       bit en, bit vld, string tag);
    @(negedge clk);
    fundIn = SW'(f); harm3In = SW'(h3); harm5In = SW'(h5); harm7In = SW'(h7);
    prop3 = PW'(p3); prop5 = PW'(p5); prop7 = PW'(p7);
    enN = ~en; inValid = vld;
    if (en && vld) begin
      expQ.push_back(f + scaled(h3, p3) + scaled(h5, p5) + scaled(h7, p7));
      cycQ.push_back(cycCnt + 3);
      tagQ.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(0, "R6 unexpected outValid", 1, 0);
        end else begin
          int e, c;
          string t;
          e = expQ.pop_front(); c = cycQ.pop_front(); t = tagQ.pop_front();
          check(int'(outSum) == e, t, int'(outSum), e);
          check(cycCnt == c, "R5 R9 arrival cycle", cycCnt, c);
        end
        lastSum = int'(outSum);
      end else if (cycCnt > 0) begin
        check(int'(outSum) == lastSum, "R8 hold", int'(outSum), lastSum);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 0, "R7 outValid in reset", outValid, 0);
    check(outSum == 0, "R7 outSum in reset", int'(outSum), 0);
    @(negedge clk) rst = 0;
    check(outValid == 0, "R7 outValid after reset", outValid, 0);
    idle(2);

    // R4 all weights zero
    drive(100, -77, 55, 127, 0, 0, 0, 1, 1, "R4 zero weights");
    drive(-128, 127, -128, 5, 0, 0, 0, 1, 1, "R4 zero weights neg");
    // R2 truncation toward zero
    drive(0, -1, 0, 0, 50, 0, 0, 1, 1, "R2 -1*50");
    drive(0, -3, -99, -128, 33, 1, 50, 1, 1, "R2 negative products");
    // R3 saturation above 50
    drive(10, 100, 100, 100, 51, 127, 90, 1, 1, "R3 saturation");
    // R10 extremes at maximum weight
    drive(127, 127, 127, 127, 50, 50, 50, 1, 1, "R10 max positive");
    drive(-128, -128, -128, -128, 127, 50, 64, 1, 1, "R10 max negative");
    // R1 typical values
    drive(60, 40, -20, 13, 50, 25, 17, 1, 1, "R1 typical");
    idle(5);

    // R6 refused inputs
    drive(50, 50, 50, 50, 10, 10, 10, 0, 1, "R6");
    drive(51, 50, 50, 50, 10, 10, 10, 0, 1, "R6");
    idle(5);

    // R9 long back-to-back stream plus R1 random with enable toggling
    for (int i = 0; i < 300; i++) begin
      bit en;
      en = (i < 100) ? 1'b1 : ($urandom_range(0, 3) != 0);
      drive($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
            $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
            $urandom_range(0, 127), $urandom_range(0, 50), $urandom_range(0, 60),
            en, $urandom_range(0, 4) != 0, "R1 R9 random");
    end
    idle(8);
    check(expQ.size() == 0, "R5 all results delivered", expQ.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule